// File: doc/BRIEF.md
# Compressed-aware instruction length stage

This stage sits between the fetch queue and the decoder. It consumes a stream of 16-bit halfwords that are sequential from the current program counter. The two lowest bits of the first halfword set the instruction length. It then emits one instruction word per transfer, along with the instruction's own address and the address of the sequential successor. A 32-bit instruction whose two halves arrive in separate transfers is parked in a one-halfword buffer. The output stays quiet until the upper half arrives.

A redirect port loads a new program counter, for example after a taken jump. The target is checked for alignment, and the rule depends on whether compressed instructions are enabled. With the extension on, only bit 0 must be clear. With it off, both low bits must be clear. A misaligned target produces a fault record that carries the address of the redirecting instruction. A 16-bit encoding seen while the extension is off produces an illegal-instruction fault record that carries the instruction's address. After either fault the stage accepts no halfwords until the next redirect.

Top module: `insn_len_stage`

## Requirements
- R1: A halfword whose bits [1:0] differ from 2'b11 starts a 16-bit instruction. It is emitted with `out_short`=1 and bits [31:16] of `out_insn` equal to zero.
- R2: A halfword whose bits [1:0] are 2'b11 starts a 32-bit instruction. The emitted word is {second halfword, first halfword}, with `out_short`=0 and `out_pc` equal to the address of the first halfword.
- R3: For a non-fault record, `out_next_pc` is `out_pc`+2 for a 16-bit instruction and `out_pc`+4 for a 32-bit one. The next record's `out_pc` equals that value.
- R4: While the lower half of a 32-bit instruction waits for its upper half, no record is emitted, however many cycles pass.
- R5: When compressed instructions are disabled (`cmp_en`=0), a 16-bit encoding produces a record with `out_illegal`=1. That record has `out_pc` equal to the instruction address and the halfword in `out_insn[15:0]`. `hw_ready` then stays 0 until a redirect.
- R6: With `cmp_en`=0, a redirect target with either of bits [1:0] set produces a record with `out_misalign`=1 and `out_pc` equal to `redir_src`. `out_illegal` and `out_misalign` are never both 1.
- R7: With `cmp_en`=1, a target with bit 0 set is misaligned (R6 record format). A target with only bit 1 set is accepted and becomes the next `out_pc`.
- R8: An accepted redirect discards any buffered lower half and any undelivered record. Decoding restarts at the target.
- R9: While `out_valid`=1 and `out_ready`=0, the record stays unchanged and `hw_ready` is 0.
- R10: After reset `out_valid` is 0, `hw_ready` is 1, and the first instruction is reported at `RESET_PC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_en | input | 1 | Compressed instructions enabled |
| redir_valid | input | 1 | Load a new program counter this cycle |
| redir_src | input | AW | Address of the instruction causing the redirect |
| redir_target | input | AW | New program counter |
| hw_valid | input | 1 | Halfword available |
| hw_data | input | 16 | Halfword at the current fetch address |
| hw_ready | output | 1 | Stage accepts a halfword |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_insn | output | 32 | Instruction word (upper half zero for 16-bit) |
| out_pc | output | AW | Instruction address, or faulting address |
| out_next_pc | output | AW | Sequential successor address |
| out_short | output | 1 | Record holds a 16-bit instruction |
| out_illegal | output | 1 | Illegal-instruction fault record |
| out_misalign | output | 1 | Misaligned-target fault record |

## Verification
The assertions assume that `redir_valid` is never raised while an undelivered record is waiting. They also assume that `cmp_en` changes only around a redirect, so the length and alignment rules apply to a stable mode. The stimulus respects both. It changes `cmp_en` only while the stage is idle, and issues each redirect only after the previous record has been drained through `out_ready`. The halfword stream is sequential from the last accepted target. The stimulus includes deliberate gaps in `hw_valid` between the two halves of a 32-bit instruction, and a stretch with `out_ready` held low.

// File: rtl/insn_len_stage.sv
module insn_len_stage #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_PC = AW'('h100)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_en,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_src,
  input  logic [AW-1:0] redir_target,
  input  logic          hw_valid,
  input  logic [15:0]   hw_data,
  output logic          hw_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_insn,
  output logic [AW-1:0] out_pc,
  output logic [AW-1:0] out_next_pc,
  output logic          out_short,
  output logic          out_illegal,
  output logic          out_misalign
);

  localparam logic [AW-1:0] STEP16 = AW'(2);
  localparam logic [AW-1:0] STEP32 = AW'(4);

  logic [AW-1:0] pc_q;
  logic          lo_vld_q;
  logic [15:0]   lo_q;
  logic          halt_q;

  logic take, short_enc, tgt_bad, slot_free;

  assign slot_free = !out_valid || out_ready;
  assign hw_ready  = !halt_q && !redir_valid && slot_free;
  assign take      = hw_valid && hw_ready;
  assign short_enc = hw_data[1:0] != 2'b11;
  assign tgt_bad   = cmp_en ? redir_target[0] : (redir_target[1:0] != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q         <= RESET_PC;
      lo_vld_q     <= 1'b0;
      lo_q         <= '0;
      halt_q       <= 1'b0;
      out_valid    <= 1'b0;
      out_insn     <= '0;
      out_pc       <= '0;
      out_next_pc  <= '0;
      out_short    <= 1'b0;
      out_illegal  <= 1'b0;
      out_misalign <= 1'b0;
    end else if (redir_valid) begin
      lo_vld_q <= 1'b0;
      if (tgt_bad) begin
        halt_q       <= 1'b1;
        out_valid    <= 1'b1;
        out_insn     <= '0;
        out_pc       <= redir_src;
        out_next_pc  <= redir_target;
        out_short    <= 1'b0;
        out_illegal  <= 1'b0;
        out_misalign <= 1'b1;
      end else begin
        halt_q    <= 1'b0;
        out_valid <= 1'b0;
        pc_q      <= redir_target;
      end
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        if (lo_vld_q) begin
          lo_vld_q     <= 1'b0;
          out_valid    <= 1'b1;
          out_insn     <= {hw_data, lo_q};
          out_pc       <= pc_q;
          out_next_pc  <= pc_q + STEP32;
          out_short    <= 1'b0;
          out_illegal  <= 1'b0;
          out_misalign <= 1'b0;
          pc_q         <= pc_q + STEP32;
        end else if (short_enc) begin
          out_valid    <= 1'b1;
          out_insn     <= {16'h0000, hw_data};
          out_pc       <= pc_q;
          out_short    <= 1'b1;
          out_misalign <= 1'b0;
          if (cmp_en) begin
            out_next_pc <= pc_q + STEP16;
            out_illegal <= 1'b0;
            pc_q        <= pc_q + STEP16;
          end else begin
            out_next_pc <= pc_q;
            out_illegal <= 1'b1;
            halt_q      <= 1'b1;
          end
        end else begin
          lo_vld_q <= 1'b1;
          lo_q     <= hw_data;
        end
      end
    end
  end

  AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !redir_valid |=> out_valid && $stable(out_insn) && $stable(out_pc)); // R9
  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !hw_ready); // R9
  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_illegal || out_misalign) |-> !hw_ready); // R5
  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_illegal, out_misalign})); // R6
  AST_LEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_misalign |-> out_short == (out_insn[1:0] != 2'b11)); // R1
  AST_SHORT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_short |-> out_insn[31:16] == 16'h0000); // R1
  AST_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal && !out_misalign |->
      out_next_pc == out_pc + (out_short ? STEP16 : STEP32)); // R3

endmodule

// File: tb/insn_len_stage_test.sv
module insn_len_stage_test;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0, cmp_en = 1'b1;
  logic redir_valid = 1'b0;
  logic [AW-1:0] redir_src = '0, redir_target = '0;
  logic hw_valid = 1'b0;
  logic [15:0] hw_data = '0;
  logic hw_ready, out_valid, out_ready = 1'b1;
  logic [31:0] out_insn;
  logic [AW-1:0] out_pc, out_next_pc;
  logic out_short, out_illegal, out_misalign;

  insn_len_stage #(.AW(AW), .RESET_PC(32'h100)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en),
    .redir_valid(redir_valid), .redir_src(redir_src), .redir_target(redir_target),
    .hw_valid(hw_valid), .hw_data(hw_data), .hw_ready(hw_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
    .out_pc(out_pc), .out_next_pc(out_next_pc), .out_short(out_short),
    .out_illegal(out_illegal), .out_misalign(out_misalign));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, c_n = 0;
  logic [31:0]   c_insn [0:31];
  logic [AW-1:0] c_pc   [0:31];
  logic [AW-1:0] c_nx   [0:31];
  logic [2:0]    c_fl   [0:31];

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && c_n < 32) begin
      c_insn[c_n] = out_insn;
      c_pc[c_n]   = out_pc;
      c_nx[c_n]   = out_next_pc;
      c_fl[c_n]   = {out_short, out_illegal, out_misalign};
      c_n++;
    end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_rec(input string req, input int i, input logic [31:0] insn,
                         input logic [AW-1:0] pc, input logic [AW-1:0] nx,
                         input logic [2:0] fl, input bit check_nx);
    chk({req, " count"}, 64'(c_n > i), 64'd1);
    chk({req, " insn"}, 64'(c_insn[i]), 64'(insn));
    chk({req, " pc"}, 64'(c_pc[i]), 64'(pc));
    chk({req, " flags"}, 64'(c_fl[i]), 64'(fl));
    if (check_nx) chk({req, " next"}, 64'(c_nx[i]), 64'(nx));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [15:0] h);
    @(posedge clk); #2;
    hw_valid = 1'b1; hw_data = h;
    forever begin
      @(negedge clk);
      if (hw_ready) begin
        @(posedge clk); #2;
        hw_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic redirect(input logic [AW-1:0] src, input logic [AW-1:0] tgt);
    @(posedge clk); #2;
    redir_valid = 1'b1; redir_src = src; redir_target = tgt;
    @(posedge clk); #2;
    redir_valid = 1'b0;
  endtask

  task automatic t_reset;
    idle(1);
    chk("R10 out_valid", 64'(out_valid), 64'd0);
    chk("R10 hw_ready", 64'(hw_ready), 64'd1);
  endtask

  task automatic t_mixed;
    put(16'h4501); put(16'h0513); put(16'h00a0); put(16'h8082);
    idle(2);
    chk_rec("R10 R1 R3 first", 0, 32'h0000_4501, 32'h100, 32'h102, 3'b100, 1);
    chk_rec("R2 R3 wide", 1, 32'h00a0_0513, 32'h102, 32'h106, 3'b000, 1);
    chk_rec("R1 R3 short", 2, 32'h0000_8082, 32'h106, 32'h108, 3'b100, 1);
  endtask

  task automatic t_straddle;
    put(16'h1113);
    idle(5);
    chk("R4 no record", 64'(out_valid), 64'd0);
    chk("R4 count", 64'(c_n), 64'd3);
    put(16'habcd);
    idle(2);
    chk_rec("R4 R2 joined", 3, 32'habcd_1113, 32'h108, 32'h10c, 3'b000, 1);
  endtask

  task automatic t_backpressure;
    @(posedge clk); #2; out_ready = 1'b0;
    put(16'h4505);
    idle(2);
    chk("R9 valid", 64'(out_valid), 64'd1);
    chk("R9 insn", 64'(out_insn), 64'h4505);
    chk("R9 ready low", 64'(hw_ready), 64'd0);
    idle(2);
    chk("R9 held", 64'(out_insn), 64'h4505);
    @(posedge clk); #2; out_ready = 1'b1;
    idle(2);
    chk_rec("R9 drained", 4, 32'h0000_4505, 32'h10c, 32'h10e, 3'b100, 1);
  endtask

  task automatic t_flush;
    put(16'h2223);
    redirect(32'h10e, 32'h200);
    put(16'h4509);
    idle(2);
    chk_rec("R8 restart", 5, 32'h0000_4509, 32'h200, 32'h202, 3'b100, 1);
    redirect(32'h200, 32'h206);
    put(16'h0001);
    idle(2);
    chk_rec("R7 bit1 target", 6, 32'h0000_0001, 32'h206, 32'h208, 3'b100, 1);
  endtask

  task automatic t_mis_on;
    redirect(32'h300, 32'h303);
    idle(2);
    chk_rec("R7 bit0 misaligned", 7, 32'h0, 32'h300, 32'h0, 3'b001, 0);
    chk("R7 halted", 64'(hw_ready), 64'd0);
  endtask

  task automatic t_ext_off;
    @(posedge clk); #2; cmp_en = 1'b0;
    redirect(32'h400, 32'h402);
    idle(2);
    chk_rec("R6 misaligned", 8, 32'h0, 32'h400, 32'h0, 3'b001, 0);
    redirect(32'h404, 32'h500);
    put(16'h0013); put(16'h0000);
    idle(2);
    chk_rec("R2 ext off wide", 9, 32'h0000_0013, 32'h500, 32'h504, 3'b000, 1);
    put(16'h4501);
    idle(2);
    chk_rec("R5 illegal", 10, 32'h0000_4501, 32'h504, 32'h0, 3'b110, 0);
    idle(3);
    chk("R5 stays halted", 64'(hw_ready), 64'd0);
    chk("R5 no more records", 64'(c_n), 64'd11);
    redirect(32'h504, 32'h600);
    idle(1);
    chk("R5 redirect resumes", 64'(hw_ready), 64'd1);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_mixed();
    t_straddle();
    t_backpressure();
    t_flush();
    t_mis_on();
    t_ext_off();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule